// File: doc/BRIEF.md
# Vector Right-Shift-and-Accumulate Unit

This block performs an element-wise right shift by an immediate amount on a 128-bit source vector. It can optionally add each shifted lane into the matching lane of a destination vector. A single 6-bit immediate and a length bit set both the lane width and the shift distance. The position of the leading one in the upper immediate bits gives the lane width, and the shift distance is whatever remains below twice that width. A signedness select picks zero fill or sign fill, and a width select limits the operation to the low 64 bits.

The block also rejects two kinds of illegal encoding. One is an immediate whose upper field is empty, which belongs to a different instruction class. The other is a 128-bit operation that names an odd register. Operands are captured on a valid strobe. The result, the undefined flag and an output valid appear one clock later. The register file, fetch and the rest of opcode decode stay with the caller.

Top module: `simd_sra_unit`

## Requirements
- R1: With `wide_lane_i`=1 the lanes are 64 bits and the shift distance is 64 minus `imm_i`, so `imm_i`=0 shifts by 64.
- R2: With `wide_lane_i`=0 the lane width is 32 if `imm_i[5]`=1, else 16 if `imm_i[4]`=1, else 8 if `imm_i[3]`=1. The shift distance is twice the lane width minus `imm_i`, which gives a value from 1 to the lane width.
- R3: With `wide_lane_i`=0 and `imm_i[5:3]`=000, the operation is flagged undefined (`undef_o`=1) and `result_o` keeps its previous value.
- R4: With `quad_i`=1 and either `dst_idx_lsb_i` or `src_idx_lsb_i` equal to 1, the operation is flagged undefined and `result_o` keeps its previous value.
- R5: `unsigned_i`=1 selects a logical shift with zero fill; `unsigned_i`=0 selects an arithmetic shift with sign fill. A shift equal to the lane width yields zero (logical) or all copies of the sign bit (arithmetic).
- R6: With `accum_i`=1 each shifted lane is added to the matching lane of `dst_i`. The sum wraps modulo 2^lane-width with no carry into the next lane. With `accum_i`=0, `dst_i` has no effect.
- R7: With `quad_i`=0, only bits [63:0] are computed and `result_o[127:64]` is zero.
- R8: `valid_o` is high exactly one cycle after a cycle with `valid_i` high. Without `valid_i`, `result_o` and `undef_o` hold their values.
- R9: After reset, `valid_o`, `undef_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand strobe |
| src_i | input | 128 | Vector to shift |
| dst_i | input | 128 | Accumulator vector |
| imm_i | input | 6 | Lane size / shift immediate |
| wide_lane_i | input | 1 | Selects 64-bit lanes |
| unsigned_i | input | 1 | 1: logical shift, 0: arithmetic shift |
| quad_i | input | 1 | 1: 128-bit operation, 0: 64-bit |
| accum_i | input | 1 | Add shifted lanes into dst_i |
| dst_idx_lsb_i | input | 1 | Low bit of destination register index |
| src_idx_lsb_i | input | 1 | Low bit of source register index |
| valid_o | output | 1 | Result strobe |
| result_o | output | 128 | Result vector |
| undef_o | output | 1 | Illegal encoding flag |

## Verification
The bound checker watches the control side on every cycle. It checks the one-cycle valid latency and that outputs hold while idle. It checks that both illegal encodings raise the flag and freeze the result, that legal encodings clear the flag, and that the upper half is zero for 64-bit operations. The lane arithmetic can only be shown by the bench's scenarios, which compare against an independent model. That arithmetic covers the leading-one width decode, the shift distance, the sign versus zero fill at the full-width shift, and accumulation that wraps inside a lane without carrying into its neighbour.

// File: rtl/simd_sra_pkg.sv
package simd_sra_pkg;
  localparam int unsigned VEC_W   = 128;
  localparam int unsigned HALF_W  = VEC_W / 2;
  localparam int unsigned IMM_W   = 6;
  localparam int unsigned SHAMT_W = IMM_W + 1;
  localparam int unsigned N_SIZES = 4;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/simd_sra_decode.sv
module simd_sra_decode
  import simd_sra_pkg::*;
(
  input  logic [IMM_W-1:0]   imm_i,
  input  logic               wide_lane_i,
  input  logic               quad_i,
  input  logic               dst_lsb_i,
  input  logic               src_lsb_i,
  output lane_sz_e           lane_sz_o,
  output logic [SHAMT_W-1:0] shamt_o,
  output logic               undef_o
);
  logic [SHAMT_W-1:0] imm_ext;
  logic               rsv_enc;

  assign imm_ext = {1'b0, imm_i};

  always_comb begin
    lane_sz_o = LANE_64;
    shamt_o   = SHAMT_W'(64) - imm_ext;
    rsv_enc   = 1'b0;
    if (!wide_lane_i) begin
      casez (imm_i[5:3])
        3'b1??: begin lane_sz_o = LANE_32; shamt_o = SHAMT_W'(64) - imm_ext; end
        3'b01?: begin lane_sz_o = LANE_16; shamt_o = SHAMT_W'(32) - imm_ext; end
        3'b001: begin lane_sz_o = LANE_8;  shamt_o = SHAMT_W'(16) - imm_ext; end
        default: begin
          lane_sz_o = LANE_8;
          shamt_o   = '0;
          rsv_enc   = 1'b1;
        end
      endcase
    end
  end

  // odd register in a 128-bit op is illegal; empty size field is another class
  assign undef_o = rsv_enc | (quad_i & (dst_lsb_i | src_lsb_i));
endmodule

// File: rtl/simd_sra_lane.sv
module simd_sra_lane
  import simd_sra_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0]  src_i,
  input  logic [LANE_W-1:0]  dst_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               unsigned_i,
  input  logic               accum_i,
  output logic [LANE_W-1:0]  res_o
);
  localparam int unsigned EXT_W = 2 * LANE_W;

  logic              fill;
  logic [EXT_W-1:0]  ext;
  logic [EXT_W-1:0]  ext_sh;
  logic [LANE_W-1:0] shifted;

  assign fill    = ~unsigned_i & src_i[LANE_W-1];
  // double-width operand keeps a full-width shift well defined
  assign ext     = {{LANE_W{fill}}, src_i};
  assign ext_sh  = ext >> shamt_i;
  assign shifted = ext_sh[LANE_W-1:0];
  assign res_o   = accum_i ? (shifted + dst_i) : shifted;
endmodule

// File: rtl/simd_sra_vec.sv
module simd_sra_vec
  import simd_sra_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0]  src_i,
  input  logic [DATA_W-1:0]  dst_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               unsigned_i,
  input  logic               accum_i,
  output logic [DATA_W-1:0]  res_o
);
  localparam int unsigned N_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    simd_sra_lane #(.LANE_W(LANE_W)) u_lane (
      .src_i      (src_i[l*LANE_W +: LANE_W]),
      .dst_i      (dst_i[l*LANE_W +: LANE_W]),
      .shamt_i    (shamt_i),
      .unsigned_i (unsigned_i),
      .accum_i    (accum_i),
      .res_o      (res_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_sra_unit.sv
module simd_sra_unit
  import simd_sra_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [VEC_W-1:0]   src_i,
  input  logic [VEC_W-1:0]   dst_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic               wide_lane_i,
  input  logic               unsigned_i,
  input  logic               quad_i,
  input  logic               accum_i,
  input  logic               dst_idx_lsb_i,
  input  logic               src_idx_lsb_i,
  output logic               valid_o,
  output logic [VEC_W-1:0]   result_o,
  output logic               undef_o
);
  lane_sz_e           lane_sz;
  logic [SHAMT_W-1:0] shamt;
  logic               dec_undef;
  logic [VEC_W-1:0]   size_res [N_SIZES];
  logic [VEC_W-1:0]   sel_res;
  logic [VEC_W-1:0]   half_mask;
  logic               valid_q;
  logic               undef_q;
  logic [VEC_W-1:0]   res_q;

  simd_sra_decode u_dec (
    .imm_i       (imm_i),
    .wide_lane_i (wide_lane_i),
    .quad_i      (quad_i),
    .dst_lsb_i   (dst_idx_lsb_i),
    .src_lsb_i   (src_idx_lsb_i),
    .lane_sz_o   (lane_sz),
    .shamt_o     (shamt),
    .undef_o     (dec_undef)
  );

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    simd_sra_vec #(.DATA_W(VEC_W), .LANE_W(8 << s)) u_vec (
      .src_i      (src_i),
      .dst_i      (dst_i),
      .shamt_i    (shamt),
      .unsigned_i (unsigned_i),
      .accum_i    (accum_i),
      .res_o      (size_res[s])
    );
  end

  assign half_mask = quad_i ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  always_comb begin
    unique case (lane_sz)
      LANE_8:  sel_res = size_res[0];
      LANE_16: sel_res = size_res[1];
      LANE_32: sel_res = size_res[2];
      default: sel_res = size_res[3];
    endcase
    sel_res = sel_res & half_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      undef_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        undef_q <= dec_undef;
        if (!dec_undef) res_q <= sel_res;
      end
    end
  end

  assign valid_o  = valid_q;
  assign undef_o  = undef_q;
  assign result_o = res_q;
endmodule

// File: rtl/simd_sra_chk.sv
module simd_sra_chk
  import simd_sra_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [VEC_W-1:0]   src_i,
  input logic [VEC_W-1:0]   dst_i,
  input logic [IMM_W-1:0]   imm_i,
  input logic               wide_lane_i,
  input logic               unsigned_i,
  input logic               quad_i,
  input logic               accum_i,
  input logic               dst_idx_lsb_i,
  input logic               src_idx_lsb_i,
  input logic               valid_o,
  input logic [VEC_W-1:0]   result_o,
  input logic               undef_o
);
  logic rsv_in;
  logic odd_in;

  assign rsv_in = ~wide_lane_i & (imm_i[5:3] == 3'b000);
  assign odd_in = quad_i & (dst_idx_lsb_i | src_idx_lsb_i);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(undef_o))); // R8
  AST_RSV_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsv_in) |=> (undef_o && $stable(result_o))); // R3
  AST_ODD_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && odd_in) |=> (undef_o && $stable(result_o))); // R4
  AST_LEGAL_DEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rsv_in && !odd_in) |=> !undef_o); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !quad_i && !rsv_in) |=> (result_o[VEC_W-1:HALF_W] == '0)); // R7
endmodule

bind simd_sra_unit simd_sra_chk u_chk (.*);

// File: tb/simd_sra_unit_bench.sv
`timescale 1ns/1ps
module simd_sra_unit_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src_i = '0;
  logic [127:0] dst_i = '0;
  logic [5:0]   imm_i = '0;
  logic         wide_lane_i = 1'b0;
  logic         unsigned_i = 1'b0;
  logic         quad_i = 1'b0;
  logic         accum_i = 1'b0;
  logic         dst_idx_lsb_i = 1'b0;
  logic         src_idx_lsb_i = 1'b0;
  logic         valid_o;
  logic [127:0] result_o;
  logic         undef_o;

  int checks = 0;
  int failures = 0;
  logic [127:0] exp_res = '0;

  always #2 clk_i = ~clk_i;

  simd_sra_unit u_simd_sra_unit (.*);

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // independent model: returns {undef, result}
  function automatic logic [128:0] model(logic [127:0] s, logic [127:0] d, logic [5:0] imm,
      logic l, logic u, logic q, logic acc, logic dl, logic sl, logic [127:0] prev);
    int w = 0;
    int sh;
    logic [127:0] r = '0;
    logic [127:0] mask;
    if (l) w = 64;
    else if (imm[5]) w = 32;
    else if (imm[4]) w = 16;
    else if (imm[3]) w = 8;
    if (w == 0 || (q && (dl || sl))) return {1'b1, prev};
    sh = 2 * w - int'(imm);
    if (l) sh = 64 - int'(imm);
    mask = (128'd1 << w) - 128'd1;
    for (int i = 0; i < (q ? 128 : 64) / w; i++) begin
      logic [127:0] lane = (s >> (i * w)) & mask;
      logic [127:0] dlane = (d >> (i * w)) & mask;
      logic signed [127:0] sv;
      logic [127:0] o;
      sv = lane;
      if (!u && lane[w-1]) sv = lane | ~mask;
      o = u ? (lane >> sh) : 128'(sv >>> sh);
      o &= mask;
      if (acc) o = (o + dlane) & mask;
      r |= o << (i * w);
    end
    return {1'b0, r};
  endfunction

  task automatic run_op(string req, logic [127:0] s, logic [127:0] d, logic [5:0] imm,
      logic l, logic u, logic q, logic acc, logic dl, logic sl);
    logic [128:0] e;
    e = model(s, d, imm, l, u, q, acc, dl, sl, exp_res);
    @(negedge clk_i);
    src_i = s; dst_i = d; imm_i = imm; wide_lane_i = l; unsigned_i = u;
    quad_i = q; accum_i = acc; dst_idx_lsb_i = dl; src_idx_lsb_i = sl; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " valid"}, 128'(valid_o), 128'd1);
    check({req, " undef"}, 128'(undef_o), 128'(e[128]));
    check({req, " result"}, result_o, e[127:0]);
    exp_res = e[127:0];
  endtask

  task automatic t_reset;
    check("R9 valid", 128'(valid_o), '0);
    check("R9 undef", 128'(undef_o), '0);
    check("R9 result", result_o, '0);
  endtask

  task automatic t_byte_arith;
    run_op("R2 R5 8b arith", 128'h80ff_7f01_c3a5_1234_fedc_ba98_7654_3210,
           '0, 6'd8, 0, 0, 1, 0, 0, 0); // shift 8 -> sign lanes
    run_op("R2 R5 8b shr3", 128'h80ff_7f01_c3a5_1234_fedc_ba98_7654_3210,
           '0, 6'd13, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_half_logical;
    run_op("R2 R5 16b logical", 128'h8001_ffff_1234_8000_0001_7fff_abcd_f00f,
           128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff, 6'd17, 0, 1, 1, 0, 0, 0); // R6 dst ignored
    run_op("R5 16b full logical", 128'h8001_ffff_1234_8000_0001_7fff_abcd_f00f,
           '0, 6'd16, 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_accum_wrap;
    run_op("R6 8b wrap", {16{8'h10}}, {16{8'hff}}, 6'd12, 0, 1, 1, 1, 0, 0);
    run_op("R6 32b arith acc", 128'h8000_0000_ffff_fff0_7fff_ffff_0000_0100,
           128'h0000_0001_0000_0005_8000_0000_ffff_ffff, 6'd60, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_dword;
    run_op("R1 R5 64b shift64 arith", 128'h8000_0000_0000_0001_7fff_ffff_ffff_ffff,
           '0, 6'd0, 1, 0, 1, 0, 0, 0);
    run_op("R1 64b shift1 logical acc", 128'h8000_0000_0000_0001_7fff_ffff_ffff_ffff,
           128'hffff_ffff_ffff_ffff_0000_0000_0000_0001, 6'd63, 1, 1, 1, 1, 0, 0);
    run_op("R1 64b shift20 arith", 128'hf123_4567_89ab_cdef_0123_4567_89ab_cdef,
           '0, 6'd44, 1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_narrow;
    run_op("R7 64-bit op upper zero", {8{16'h8421}}, {8{16'h1111}}, 6'd20, 0, 0, 0, 1, 1, 1);
  endtask

  task automatic t_reserved;
    run_op("R3 reserved imm", {16{8'haa}}, '0, 6'd5, 0, 0, 1, 0, 0, 0);
    run_op("R3 reserved imm zero", '1, '1, 6'd0, 0, 1, 0, 1, 0, 0);
  endtask

  task automatic t_odd_reg;
    run_op("R4 odd dst", {16{8'h77}}, '0, 6'd9, 0, 1, 1, 0, 1, 0);
    run_op("R4 odd src", {16{8'h77}}, '0, 6'd9, 0, 1, 1, 0, 0, 1);
    run_op("R4 odd ok in 64-bit op", {16{8'h77}}, '0, 6'd9, 0, 1, 0, 0, 1, 1);
  endtask

  task automatic t_idle_hold;
    logic [127:0] held;
    held = result_o;
    @(negedge clk_i);
    src_i = '1; imm_i = 6'd8; quad_i = 1'b1;
    @(negedge clk_i);
    check("R8 no valid", 128'(valid_o), '0);
    check("R8 result held", result_o, held);
    check("R8 undef held", 128'(undef_o), '0);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_byte_arith();
    t_half_logical();
    t_accum_wrap();
    t_dword();
    t_narrow();
    t_reserved();
    t_odd_reg();
    t_idle_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule